// File: doc/BRIEF.md
# Auto-Reload Timer with Capture

This block is a 16-bit up-counter kept as two 8-bit bytes behind a small register port. In its default mode the two bytes act as one 16-bit counter that, on wrapping past its maximum, reloads from a 16-bit reload register and sets a high overflow flag. In split mode the bytes become two independent 8-bit auto-reload counters. In capture mode the counter runs freely, and each rising edge of a measured signal copies the count into the reload register. The interval between two captures then gives the period of that signal in count-clock ticks.

The count clock is one of four sources: the system clock, the system clock divided by 12, an external clock divided by 8, and a comparator output. The external clock and the comparator output are asynchronous. Each passes through a two-flop synchronizer and a rising-edge detector, and each source then yields a one-cycle count enable. The block raises a level interrupt request from its sticky flags. Software clears a flag by writing 0 to it.

Top module: `reload_timer`

## Requirements
- R1: After reset every register (addresses 0 to 5) reads 0 and irq_o is low.
- R2: Register map: 0 control, 1 count low byte, 2 count high byte, 3 reload low byte, 4 reload high byte, 5 config. Control bits are [1:0] source select, [2] run, [3] split, [4] capture, [5] low-overflow interrupt enable, [6] low flag, [7] high flag. Config bits are [0] interrupt enable and [1] capture source (0 = external/8, 1 = comparator). The reload and config registers read back what was written, and addresses 6 and 7 read 0.
- R3: In 16-bit mode (split and capture clear), a count enable at 0xFFFF loads the 16-bit reload value into the counter and sets the high flag.
- R4: Each time the low byte rolls from 0xFF to 0x00 or reloads from 0xFF, the low flag is set, in every mode.
- R5: irq_o is high exactly when interrupt enable is set and either the high flag is set, or the low flag and the low-overflow interrupt enable are both set.
- R6: Source select 11 gives one count per system clock cycle, and source select 00 gives one count per 12 system clock cycles.
- R7: Source select 01 gives one count per 8 synchronized rising edges of ext_clk_i. Source select 10 gives one count per synchronized rising edge of cmp_i.
- R8: While run is clear the count does not change except by register writes.
- R9: In split mode the low byte counts on the selected source, the high byte counts every system clock cycle while run is set, and each byte reloads from its own reload byte on its own 0xFF overflow. Only the high byte's overflow sets the high flag.
- R10: In capture mode each rising edge of the selected capture source copies the current 16-bit count into the reload register and sets the high flag. The counter then wraps freely without reloading.
- R11: Writing 0 to a flag bit clears it. A hardware flag set in the same cycle as such a write wins, and the flag stays set.
- R12: A write to either count byte stores the written value, and no count takes place in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | Asynchronous external clock |
| cmp_i | input | 1 | Asynchronous comparator output |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt request |

## Verification
A high overflow and a software write that clears the high flag can fall in the same cycle. The bench sets up that collision with three consecutive register writes: count low = 0xFF, count high = 0xFF, then a control write with the flags at 0 and run still set, so the wrap from 0xFFFF lands on the clearing write's clock edge. The flag must read 1 afterwards. A clearing write with no overflow pending must leave it at 0. The same burst also shows that the byte writes suppress counting, since the wrap takes place only on the third edge.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    SRC_DIV12 = 2'b00,
    SRC_EXT8  = 2'b01,
    SRC_CMP   = 2'b10,
    SRC_SYS   = 2'b11
  } src_e;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CNT_LO = 3'd1,
    A_CNT_HI = 3'd2,
    A_RLD_LO = 3'd3,
    A_RLD_HI = 3'd4,
    A_CFG    = 3'd5
  } addr_e;
endpackage

// File: rtl/rt_sync_edge.sv
module rt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rt_tick_gen.sv
module rt_tick_gen
  import rt_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_clk_i,
  input  logic       cmp_i,
  input  logic [1:0] src_sel_i,
  input  logic       cap_src_i,
  output logic       tick_o,
  output logic       cap_evt_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int DW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;

  logic          ext_rise, cmp_rise;
  logic [PW-1:0] pre_q;
  logic [DW-1:0] div_q;
  logic          pre_tick, ext_tick;

  rt_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ext_clk_i), .rise_o(ext_rise)
  );
  rt_sync_edge #(.STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(cmp_i), .rise_o(cmp_rise)
  );

  // free-running system clock prescaler
  assign pre_tick = (pre_q == PW'(PRESCALE - 1));
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pre_q <= '0;
    else if (pre_tick) pre_q <= '0;
    else               pre_q <= pre_q + PW'(1);
  end

  // external edge divider
  assign ext_tick = ext_rise && (div_q == DW'(EXT_DIV - 1));
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (ext_tick) div_q <= '0;
    else if (ext_rise) div_q <= div_q + DW'(1);
  end

  always_comb begin
    unique case (src_e'(src_sel_i))
      SRC_DIV12: tick_o = pre_tick;
      SRC_EXT8:  tick_o = ext_tick;
      SRC_CMP:   tick_o = cmp_rise;
      default:   tick_o = 1'b1;
    endcase
  end

  assign cap_evt_o = cap_src_i ? cmp_rise : ext_tick;
endmodule

// File: rtl/rt_counter.sv
module rt_counter
  import rt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              split_i,
  input  logic              capture_i,
  input  logic              tick_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0]  rld_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_lo_o,
  output logic              ovf_hi_o
);
  localparam logic [BYTE_W-1:0] BMAX = '1;

  logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic              wr_any, en_lo, en_hi, split_act;

  assign wr_any    = wr_lo_i | wr_hi_i;
  assign split_act = split_i & ~capture_i;
  assign en_lo     = run_i & tick_i & ~wr_any;
  assign en_hi     = run_i & ~wr_any;

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf_lo_o = 1'b0;
    ovf_hi_o = 1'b0;
    if (wr_lo_i) lo_d = wr_data_i;
    if (wr_hi_i) hi_d = wr_data_i;
    if (split_act) begin
      if (en_lo) begin
        ovf_lo_o = (lo_q == BMAX);
        lo_d     = ovf_lo_o ? rld_i[BYTE_W-1:0] : lo_q + 1'b1;
      end
      if (en_hi) begin
        ovf_hi_o = (hi_q == BMAX);
        hi_d     = ovf_hi_o ? rld_i[CNT_W-1:BYTE_W] : hi_q + 1'b1;
      end
    end else if (en_lo) begin
      ovf_lo_o = (lo_q == BMAX);
      if ({hi_q, lo_q} == {CNT_W{1'b1}}) begin
        ovf_hi_o     = ~capture_i;
        {hi_d, lo_d} = capture_i ? '0 : rld_i;
      end else begin
        {hi_d, lo_d} = {hi_q, lo_q} + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt_o = {hi_q, lo_q};
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rt_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic              cmp_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [1:0]       clk_sel;
  logic             run, split_m, cap_m, lo_ie, flag_lo, flag_hi;
  logic             irq_en, cap_src;
  logic [CNT_W-1:0] rld, cnt;
  logic             tick, cap_evt, cap_pulse, ovf_lo, ovf_hi;
  logic             wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_rld_lo, wr_rld_hi, wr_cfg;
  logic             wr_cnt_any, wr_rld_any;

  assign wr_ctrl    = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_cnt_lo  = wr_en_i && (wr_addr_i == A_CNT_LO);
  assign wr_cnt_hi  = wr_en_i && (wr_addr_i == A_CNT_HI);
  assign wr_rld_lo  = wr_en_i && (wr_addr_i == A_RLD_LO);
  assign wr_rld_hi  = wr_en_i && (wr_addr_i == A_RLD_HI);
  assign wr_cfg     = wr_en_i && (wr_addr_i == A_CFG);
  assign wr_cnt_any = wr_cnt_lo | wr_cnt_hi;
  assign wr_rld_any = wr_rld_lo | wr_rld_hi;

  rt_tick_gen #(
    .PRESCALE(PRESCALE), .EXT_DIV(EXT_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_clk_i(ext_clk_i), .cmp_i(cmp_i),
    .src_sel_i(clk_sel), .cap_src_i(cap_src), .tick_o(tick), .cap_evt_o(cap_evt)
  );

  rt_counter u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .split_i(split_m),
    .capture_i(cap_m), .tick_i(tick), .wr_lo_i(wr_cnt_lo), .wr_hi_i(wr_cnt_hi),
    .wr_data_i(wr_data_i), .rld_i(rld), .cnt_o(cnt),
    .ovf_lo_o(ovf_lo), .ovf_hi_o(ovf_hi)
  );

  assign cap_pulse = cap_m & cap_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sel <= '0;
      run     <= 1'b0;
      split_m <= 1'b0;
      cap_m   <= 1'b0;
      lo_ie   <= 1'b0;
      flag_lo <= 1'b0;
      flag_hi <= 1'b0;
      irq_en  <= 1'b0;
      cap_src <= 1'b0;
      rld     <= '0;
    end else begin
      if (wr_ctrl) begin
        clk_sel <= wr_data_i[1:0];
        run     <= wr_data_i[2];
        split_m <= wr_data_i[3];
        cap_m   <= wr_data_i[4];
        lo_ie   <= wr_data_i[5];
      end
      // hardware set wins over a software write
      flag_lo <= ovf_lo | (wr_ctrl ? wr_data_i[6] : flag_lo);
      flag_hi <= ovf_hi | cap_pulse | (wr_ctrl ? wr_data_i[7] : flag_hi);
      if (wr_cfg) begin
        irq_en  <= wr_data_i[0];
        cap_src <= wr_data_i[1];
      end
      if (cap_pulse) rld <= cnt;
      else begin
        if (wr_rld_lo) rld[BYTE_W-1:0]     <= wr_data_i;
        if (wr_rld_hi) rld[CNT_W-1:BYTE_W] <= wr_data_i;
      end
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      A_CTRL:   rd_data_o = {flag_hi, flag_lo, lo_ie, cap_m, split_m, run, clk_sel};
      A_CNT_LO: rd_data_o = cnt[BYTE_W-1:0];
      A_CNT_HI: rd_data_o = cnt[CNT_W-1:BYTE_W];
      A_RLD_LO: rd_data_o = rld[BYTE_W-1:0];
      A_RLD_HI: rd_data_o = rld[CNT_W-1:BYTE_W];
      A_CFG:    rd_data_o = {6'b0, cap_src, irq_en};
      default:  rd_data_o = '0;
    endcase
  end

  assign irq_o = irq_en & (flag_hi | (flag_lo & lo_ie));
endmodule

// File: rtl/rt_checker.sv
module rt_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        run,
  input logic        split_m,
  input logic        cap_m,
  input logic        tick,
  input logic        cap_evt,
  input logic [1:0]  clk_sel,
  input logic [15:0] cnt,
  input logic [15:0] rld,
  input logic        ovf_hi,
  input logic        wr_cnt_any,
  input logic        wr_rld_any,
  input logic        wr_ctrl,
  input logic        flag_hi,
  input logic        flag_lo,
  input logic        irq_o
);
  AST_RELOAD_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!split_m && !cap_m && ovf_hi && !wr_rld_any) |=> (cnt == $past(rld))) // R3
    else $error("reload on wrap");

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_hi || flag_lo)) // R5
    else $error("irq without flag");

  AST_SLOW_TICK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && clk_sel != 2'b11) |=> (!tick || clk_sel != $past(clk_sel))) // R7
    else $error("slow tick not a pulse");

  AST_RUN_GATES_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_cnt_any) |=> $stable(cnt)) // R8
    else $error("count moved while stopped");

  AST_CAPTURE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_m && cap_evt) |=> (rld == $past(cnt) && flag_hi)) // R10
    else $error("capture load");

  AST_FLAG_HI_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_hi && !wr_ctrl) |=> flag_hi) // R11
    else $error("high flag dropped");
endmodule

bind reload_timer rt_checker chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .run(run), .split_m(split_m), .cap_m(cap_m),
  .tick(tick), .cap_evt(cap_evt), .clk_sel(clk_sel), .cnt(cnt), .rld(rld),
  .ovf_hi(ovf_hi), .wr_cnt_any(wr_cnt_any), .wr_rld_any(wr_rld_any),
  .wr_ctrl(wr_ctrl), .flag_hi(flag_hi), .flag_lo(flag_lo), .irq_o(irq_o)
);

// File: tb/reload_timer_tb_top.sv
`timescale 1ns/1ps
module reload_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic       cmp = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  reload_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk), .cmp_i(cmp),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // combinational read, taken in the low phase
  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic rd16(input logic [2:0] a_lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(a_lo, l);
    rd(a_lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reg after reset", v, 0);
    end
    check("R1 irq after reset", irq, 0);
  endtask

  task automatic t_regmap;
    logic [7:0] v;
    wr(3'd3, 8'hA5);
    wr(3'd4, 8'h5A);
    wr(3'd5, 8'h03);
    rd(3'd3, v); check("R2 reload lo readback", v, 8'hA5);
    rd(3'd4, v); check("R2 reload hi readback", v, 8'h5A);
    rd(3'd5, v); check("R2 cfg readback", v, 8'h03);
    rd(3'd6, v); check("R2 unused addr 6", v, 0);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_sysclk_and_write;
    logic [7:0] v;
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h07);
    wait_cyc(50);
    rd(3'd1, v); check("R6 sysclk 50 cycles", v, 50);
    // R12: write lands, no increment on that edge
    wr(3'd1, 8'h10);
    rd(3'd1, v); check("R12 count write suppresses count", v, 8'h10);
    wr(3'd0, 8'h03);
  endtask

  task automatic t_run_gate;
    logic [15:0] a, b;
    rd16(3'd1, a);
    wait_cyc(50);
    rd16(3'd1, b);
    check("R8 stopped count stable", b, a);
  endtask

  task automatic t_div12;
    logic [7:0] a, b;
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h04);
    wait_cyc(3);
    rd(3'd1, a);
    wait_cyc(120);
    rd(3'd1, b);
    check("R6 div12 counts per 120 cycles", b - a, 10);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_ext8;
    logic [7:0] v;
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h05);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk) ext_clk = 1'b1;
      wait_cyc(2);
      ext_clk = 1'b0;
      wait_cyc(2);
    end
    wait_cyc(8);
    rd(3'd1, v); check("R7 ext/8 counts for 16 edges", v, 2);
    wr(3'd0, 8'h01);
  endtask

  task automatic t_cmp;
    logic [7:0] v;
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h06);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk) cmp = 1'b1;
      wait_cyc(3);
      cmp = 1'b0;
      wait_cyc(3);
    end
    wait_cyc(6);
    rd(3'd1, v); check("R7 comparator counts for 5 edges", v, 5);
    wr(3'd0, 8'h02);
  endtask

  task automatic t_wrap16;
    logic [7:0] v;
    wr(3'd1, 8'hFE);
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'h34);
    wr(3'd4, 8'h12);
    wr(3'd5, 8'h01);
    wr(3'd0, 8'h07);
    wait_cyc(10);
    rd(3'd0, v);
    check("R3 high flag on wrap", v[7], 1);
    check("R4 low flag on 16-bit wrap", v[6], 1);
    check("R5 irq from high flag", irq, 1);
    wr(3'd0, 8'h03);
    rd(3'd2, v); check("R3 reloaded high byte", v, 8'h12);
    rd(3'd0, v); check("R11 flags cleared by write 0", v[7:6], 0);
    check("R5 irq drops after clear", irq, 0);
  endtask

  task automatic t_lo_irq;
    logic [7:0] v;
    wr(3'd1, 8'hFE);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h07);
    wait_cyc(6);
    rd(3'd0, v);
    check("R4 low flag set", v[6], 1);
    check("R4 no high flag", v[7], 0);
    check("R5 no irq without low enable", irq, 0);
    wr(3'd0, 8'h63);
    check("R5 irq with low enable", irq, 1);
    wr(3'd5, 8'h00);
    check("R5 irq masked by enable", irq, 0);
    wr(3'd0, 8'h03);
  endtask

  task automatic t_split;
    logic [7:0] v;
    wr(3'd0, 8'h08);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'hF0);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h80);
    wr(3'd0, 8'h0C);
    wait_cyc(20);
    rd(3'd2, v); check("R9 high byte reloaded from its reload", v[7:4], 8);
    rd(3'd1, v); check("R9 low byte on div12", (v <= 2) ? 1 : 0, 1);
    rd(3'd0, v);
    check("R9 high flag from high byte", v[7], 1);
    check("R9 no low flag", v[6], 0);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_capture;
    logic [15:0] a, b;
    logic [7:0] v;
    wr(3'd5, 8'h02);
    wr(3'd0, 8'h17);
    @(negedge clk) cmp = 1'b1;
    wait_cyc(10);
    rd16(3'd3, a);
    cmp = 1'b0;
    wait_cyc(90);
    cmp = 1'b1;
    wait_cyc(10);
    rd16(3'd3, b);
    cmp = 1'b0;
    check("R10 capture interval", 16'(b - a), 100);
    rd(3'd0, v); check("R10 capture sets high flag", v[7], 1);
    wr(3'd0, 8'h03);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_collision;
    logic [7:0] v;
    wr(3'd0, 8'h07);
    rd(3'd0, v); check("R11 flag clear without collision", v[7], 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'hFF;
    @(negedge clk);
    wr_addr = 3'd2; wr_data = 8'hFF;
    @(negedge clk);
    wr_addr = 3'd0; wr_data = 8'h07;
    @(negedge clk);
    wr_en = 1'b0;
    rd(3'd0, v); check("R11 hw set beats sw clear", v[7], 1);
    wr(3'd0, 8'h03);
  endtask

  initial begin
    fork
      begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_regmap();
        t_sysclk_and_write();
        t_run_gate();
        t_div12();
        t_ext8();
        t_cmp();
        t_wrap16();
        t_lo_irq();
        t_split();
        t_capture();
        t_collision();
      end
      begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule